// File: doc/BRIEF.md
# Low-Bank Region Mapper with Per-Target Wait States

This block sits between a CPU and its memories and classifies every access to the low 64K address bank. Each access is steered to one of three places: a zero-wait static RAM, a slower synchronous DRAM, or the slow external system bus. The block drives a target code and a ready signal. Ready rises after the chosen target's fixed cost. For the external bus it follows the bus's completion signal. The memory controllers behind the target code are not part of the block.

Software decides what lives in fast memory by writing an 8-bit map register. The register has one 2-bit field per mappable region: zero page, stack, ROM windows and general RAM. The I/O and colour-RAM page and the video window are never remapped; they always go to the external bus. The same decision applies to reads and to writes. There is no hardware caching: placement follows the register and nothing else.

Top module: `bz_mapper`

## Requirements
- R1: After reset every mappable region goes to the external bus. Until the map register is first written, any access at 0x0000–0x01FF yields target EXT.
- R2: The regions are decoded as follows. Zero page is 0x0000–0x00FF and stack is 0x0100–0x01FF. ROM is 0xA000–0xBFFF together with 0xE000–0xFFFF. General RAM is every other address outside the fixed ranges of R7, for example 0x0200–0x03FF, 0x0800–0x9FFF and 0xC000–0xCFFF.
- R3: Map register fields are: bits [1:0] zero page, [3:2] stack, [5:4] ROM, [7:6] general RAM. Field code 01 selects static RAM and 10 selects DRAM; 00 and 11 both select the external bus. On acc_tgt, 0 means static RAM, 1 DRAM, 2 external bus and 3 the map register.
- R4: A static-RAM access has acc_ready high in the same cycle as its first acc_valid cycle, which means zero wait states.
- R5: A DRAM access has acc_ready high exactly SDRAM_WAITS cycles after its first acc_valid cycle. SDRAM_WAITS is 1 or 2 and defaults to 2.
- R6: An external-bus access has acc_ready equal to ext_done in every cycle. ext_done has no effect on accesses to any other target.
- R7: Addresses 0xD000–0xDFFF (I/O and colour RAM) and 0x0400–0x07FF (video window) always yield target EXT, whatever the map register holds.
- R8: The target does not depend on acc_we, except for the map-register write of R9.
- R9: A write at CTRL_ADDR (default 0xDF00) yields target 3 with zero waits, and it loads acc_wdata into the map register at the end of that cycle. A read at CTRL_ADDR is an ordinary I/O access to the external bus.
- R10: acc_ready is low whenever acc_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access in progress; held with its address until acc_ready |
| acc_addr | input | 16 | Address within the low bank |
| acc_we | input | 1 | 1 for a write, 0 for a read |
| acc_wdata | input | 8 | Write data; used only by a map-register write |
| ext_done | input | 1 | External bus has finished the current access |
| acc_tgt | output | 2 | Target code for the current access |
| acc_ready | output | 1 | Access completes in this cycle |

## Verification
The hardest case is a stray ext_done that arrives while a DRAM access is still counting its waits. The same case must cover a DRAM access at the exact cycle its count ends. A wrong design would finish early, or stall one cycle late, and both errors look the same at the target code. The stimulus therefore holds ext_done high for the whole of some static-RAM and DRAM accesses. It measures the wait count of every access, so that a one-cycle slip is seen. The map register is also loaded with several patterns, including the reserved code 11. The address boundaries of each region are then probed under each pattern, so that a region decoded with the wrong field shows up as a wrong target.

// File: rtl/bz_map_pkg.sv
package bz_map_pkg;

    localparam int ADDR_W  = 16;
    localparam int NUM_MAP = 4;
    localparam int FIELD_W = 2;
    localparam int CFG_W   = NUM_MAP * FIELD_W;

    // Address classes; the mappable ones index their field in the map register
    typedef enum logic [2:0] {
        RG_ZP    = 3'd0,
        RG_STK   = 3'd1,
        RG_ROM   = 3'd2,
        RG_RAM   = 3'd3,
        RG_FIXED = 3'd4
    } region_e;

    // Target codes driven on acc_tgt
    typedef enum logic [1:0] {
        TGT_SRAM  = 2'd0,
        TGT_SDRAM = 2'd1,
        TGT_EXT   = 2'd2,
        TGT_CTRL  = 2'd3
    } tgt_e;

    // Field codes in the map register
    localparam logic [FIELD_W-1:0] MAP_SRAM  = 2'b01;
    localparam logic [FIELD_W-1:0] MAP_SDRAM = 2'b10;

endpackage

// File: rtl/bz_region_dec.sv
module bz_region_dec
    import bz_map_pkg::*;
#(
    parameter int                           ROM_WIN = 2,
    parameter logic [ADDR_W-1:0]            ZP_HI   = 16'h00FF,
    parameter logic [ADDR_W-1:0]            STK_HI  = 16'h01FF,
    parameter logic [ADDR_W-1:0]            IO_LO   = 16'hD000,
    parameter logic [ADDR_W-1:0]            IO_HI   = 16'hDFFF,
    parameter logic [ADDR_W-1:0]            VID_LO  = 16'h0400,
    parameter logic [ADDR_W-1:0]            VID_HI  = 16'h07FF,
    parameter logic [ROM_WIN-1:0][ADDR_W-1:0] ROM_LO = {16'hE000, 16'hA000},
    parameter logic [ROM_WIN-1:0][ADDR_W-1:0] ROM_HI = {16'hFFFF, 16'hBFFF}
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);

    logic [ROM_WIN-1:0] rom_hit;
    logic               fixed_hit;
    logic               zp_hit;
    logic               stk_hit;

    // One comparator pair per ROM window
    for (genvar w = 0; w < ROM_WIN; w++) begin : g_rom
        assign rom_hit[w] = (addr >= ROM_LO[w]) && (addr <= ROM_HI[w]);
    end

    assign fixed_hit = ((addr >= IO_LO)  && (addr <= IO_HI)) ||
                       ((addr >= VID_LO) && (addr <= VID_HI));
    assign zp_hit    = (addr <= ZP_HI);
    assign stk_hit   = (addr >  ZP_HI) && (addr <= STK_HI);

    // Fixed ranges win over every mappable class
    always_comb begin
        if (fixed_hit)      region = RG_FIXED;
        else if (zp_hit)    region = RG_ZP;
        else if (stk_hit)   region = RG_STK;
        else if (|rom_hit)  region = RG_ROM;
        else                region = RG_RAM;
    end

endmodule

// File: rtl/bz_target_sel.sv
module bz_target_sel
    import bz_map_pkg::*;
(
    input  region_e          region,
    input  logic [CFG_W-1:0] cfg,
    input  logic             ctrl_wr,
    output tgt_e             tgt
);

    logic [FIELD_W-1:0] fld [NUM_MAP];
    logic [FIELD_W-1:0] code;

    for (genvar g = 0; g < NUM_MAP; g++) begin : g_fld
        assign fld[g] = cfg[g*FIELD_W +: FIELD_W];
    end

    always_comb begin
        code = (region == RG_FIXED) ? '0 : fld[region[1:0]];
        if (ctrl_wr) begin
            tgt = TGT_CTRL;
        end else begin
            case (code)
                MAP_SRAM:  tgt = TGT_SRAM;
                MAP_SDRAM: tgt = TGT_SDRAM;
                default:   tgt = TGT_EXT;
            endcase
        end
    end

endmodule

// File: rtl/bz_wait_seq.sv
module bz_wait_seq
    import bz_map_pkg::*;
#(
    parameter int SDRAM_WAITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  tgt_e tgt,
    input  logic ext_done,
    output logic ready
);

    localparam int CNT_W = $clog2(SDRAM_WAITS + 2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        ready = 1'b0;
        if (valid) begin
            case (tgt)
                TGT_SDRAM: ready = (seq_q.cnt == CNT_W'(SDRAM_WAITS));
                TGT_EXT:   ready = ext_done;
                default:   ready = 1'b1;
            endcase
        end
        // Count stalled cycles of the access in flight, saturating
        if (valid && !ready) begin
            if (seq_q.cnt != '1) seq_d.cnt = seq_q.cnt + 1'b1;
        end else begin
            seq_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

endmodule

// File: rtl/bz_mapper.sv
module bz_mapper
    import bz_map_pkg::*;
#(
    parameter int          SDRAM_WAITS = 2,
    parameter logic [15:0] CTRL_ADDR   = 16'hDF00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic [15:0] acc_addr,
    input  logic        acc_we,
    input  logic [7:0]  acc_wdata,
    input  logic        ext_done,
    output logic [1:0]  acc_tgt,
    output logic        acc_ready
);

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } ctl_t;

    ctl_t    ctl_d, ctl_q;
    logic    ctrl_wr;
    region_e region;
    tgt_e    tgt;

    assign ctrl_wr = acc_valid && acc_we && (acc_addr == CTRL_ADDR);

    bz_region_dec u_dec (
        .addr   (acc_addr),
        .region (region)
    );

    bz_target_sel u_sel (
        .region  (region),
        .cfg     (ctl_q.cfg),
        .ctrl_wr (ctrl_wr),
        .tgt     (tgt)
    );

    bz_wait_seq #(.SDRAM_WAITS(SDRAM_WAITS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (acc_valid),
        .tgt      (tgt),
        .ext_done (ext_done),
        .ready    (acc_ready)
    );

    assign acc_tgt = tgt;

    always_comb begin
        ctl_d = ctl_q;
        if (ctrl_wr) ctl_d.cfg = acc_wdata;
    end

    // Reset value: every field 00, all regions on the external bus
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

endmodule

// File: rtl/bz_mapper_chk.sv
module bz_mapper_chk #(
    parameter int          SDRAM_WAITS = 2,
    parameter logic [15:0] CTRL_ADDR   = 16'hDF00
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic [15:0] acc_addr,
    input logic        acc_we,
    input logic        ext_done,
    input logic [1:0]  acc_tgt,
    input logic        acc_ready
);

    logic [1:0] stall_q;
    logic       seen_wr_q;
    logic       is_ctrl_wr;
    logic       in_fixed;

    assign is_ctrl_wr = acc_valid && acc_we && (acc_addr == CTRL_ADDR);
    assign in_fixed   = ((acc_addr >= 16'hD000) && (acc_addr <= 16'hDFFF)) ||
                        ((acc_addr >= 16'h0400) && (acc_addr <= 16'h07FF));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stall_q   <= '0;
            seen_wr_q <= 1'b0;
        end else begin
            if (acc_valid && !acc_ready) begin
                if (stall_q != 2'b11) stall_q <= stall_q + 1'b1;
            end else begin
                stall_q <= '0;
            end
            if (is_ctrl_wr) seen_wr_q <= 1'b1;
        end
    end

    a_r1_reset_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_wr_q && acc_valid && (acc_addr <= 16'h01FF)) |-> (acc_tgt == 2'd2));

    a_r4_sram_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_tgt == 2'd0) |-> acc_ready);

    a_r5_sdram_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_tgt == 2'd1) |-> (acc_ready == (stall_q == 2'(SDRAM_WAITS))));

    a_r6_ext_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_tgt == 2'd2) |-> (acc_ready == ext_done));

    a_r7_fixed_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && in_fixed && !is_ctrl_wr) |-> (acc_tgt == 2'd2));

    a_r9_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        is_ctrl_wr |-> (acc_ready && acc_tgt == 2'd3));

    a_r10_idle_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !acc_ready);

endmodule

bind bz_mapper bz_mapper_chk #(
    .SDRAM_WAITS (SDRAM_WAITS),
    .CTRL_ADDR   (CTRL_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_we    (acc_we),
    .ext_done  (ext_done),
    .acc_tgt   (acc_tgt),
    .acc_ready (acc_ready)
);

// File: tb/bz_mapper_tb.sv
`timescale 1ns/1ps
module bz_mapper_tb;

    localparam int WAITS = 2;
    localparam logic [1:0] T_SRAM = 2'd0, T_SDRAM = 2'd1, T_EXT = 2'd2, T_REG = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [15:0] acc_addr = '0;
    logic        acc_we = 1'b0;
    logic [7:0]  acc_wdata = '0;
    logic        ext_done = 1'b0;
    logic [1:0]  acc_tgt;
    logic        acc_ready;

    int checks = 0;
    int fails  = 0;
    int mon_cnt = 0;

    typedef struct {
        logic [1:0]  tgt;
        int          waits;
        string       tag;
        logic [15:0] addr;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    bz_mapper #(.SDRAM_WAITS(WAITS), .CTRL_ADDR(16'hDF00)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_we(acc_we), .acc_wdata(acc_wdata), .ext_done(ext_done),
        .acc_tgt(acc_tgt), .acc_ready(acc_ready)
    );

    // Driver: queue the expectation, then run one access to completion
    task automatic do_acc(input logic [15:0] a, input logic we, input logic [7:0] wd,
                          input logic [1:0] et, input int ew, input logic hold_done,
                          input string tag);
        int n;
        exp_q.push_back('{tgt: et, waits: ew, tag: tag, addr: a});
        @(posedge clk); #1;
        acc_valid = 1'b1; acc_addr = a; acc_we = we; acc_wdata = wd;
        ext_done  = hold_done;
        n = 0;
        forever begin
            if (et == T_EXT && n == ew) ext_done = 1'b1;
            @(negedge clk);
            if (acc_ready) break;
            @(posedge clk); #1;
            n++;
            if (n > 40) break;
        end
        @(posedge clk); #1;
        acc_valid = 1'b0; acc_we = 1'b0; ext_done = 1'b0;
    endtask

    // Monitor: measure each access and compare with the queued expectation
    always @(negedge clk) begin
        if (rst_n && acc_valid) begin
            if (acc_ready) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL unexpected completion addr=%h actual tgt %0d expected none",
                             acc_addr, acc_tgt);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    checks++;
                    if (acc_tgt !== e.tgt) begin
                        fails++;
                        $display("FAIL %s addr=%h target actual %0d expected %0d",
                                 e.tag, e.addr, acc_tgt, e.tgt);
                    end
                    checks++;
                    if (mon_cnt != e.waits) begin
                        fails++;
                        $display("FAIL %s addr=%h waits actual %0d expected %0d",
                                 e.tag, e.addr, mon_cnt, e.waits);
                    end
                end
                mon_cnt = 0;
            end else begin
                mon_cnt++;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (acc_ready !== 1'b0) begin
            fails++;
            $display("FAIL R10 idle ready actual %0b expected 0", acc_ready);
        end

        // R1: reset map sends zero page and stack to the external bus
        do_acc(16'h0010, 1'b0, 8'h00, T_EXT, 1, 1'b0, "R1");
        do_acc(16'h01F0, 1'b1, 8'h00, T_EXT, 0, 1'b0, "R1");

        // R9: zp=SRAM, stack=DRAM, rom=SRAM, ram=DRAM (field layout per R3)
        do_acc(16'hDF00, 1'b1, 8'h99, T_REG, 0, 1'b0, "R9");
        do_acc(16'h00FF, 1'b0, 8'h00, T_SRAM, 0, 1'b0, "R2 R4");
        do_acc(16'h0100, 1'b1, 8'h00, T_SDRAM, WAITS, 1'b0, "R2 R5");
        do_acc(16'h01FF, 1'b0, 8'h00, T_SDRAM, WAITS, 1'b0, "R2 R5");
        do_acc(16'h0200, 1'b0, 8'h00, T_SDRAM, WAITS, 1'b0, "R2");
        do_acc(16'h03FF, 1'b1, 8'h00, T_SDRAM, WAITS, 1'b0, "R2 R8");
        do_acc(16'h0400, 1'b0, 8'h00, T_EXT, 3, 1'b0, "R7");
        do_acc(16'h07FF, 1'b1, 8'h00, T_EXT, 0, 1'b0, "R7");
        do_acc(16'h0800, 1'b0, 8'h00, T_SDRAM, WAITS, 1'b0, "R2");
        do_acc(16'h9FFF, 1'b0, 8'h00, T_SDRAM, WAITS, 1'b0, "R2");
        do_acc(16'hA000, 1'b0, 8'h00, T_SRAM, 0, 1'b0, "R2 R4");
        do_acc(16'hBFFF, 1'b1, 8'h00, T_SRAM, 0, 1'b0, "R2 R8");
        do_acc(16'hC000, 1'b0, 8'h00, T_SDRAM, WAITS, 1'b0, "R2");
        do_acc(16'hCFFF, 1'b0, 8'h00, T_SDRAM, WAITS, 1'b0, "R2");
        do_acc(16'hD000, 1'b0, 8'h00, T_EXT, 2, 1'b0, "R7");
        do_acc(16'hDFFF, 1'b1, 8'h00, T_EXT, 1, 1'b0, "R7");
        do_acc(16'hDF00, 1'b0, 8'h00, T_EXT, 1, 1'b0, "R9 read");
        do_acc(16'hE000, 1'b0, 8'h00, T_SRAM, 0, 1'b0, "R2");
        do_acc(16'hFFFF, 1'b1, 8'h00, T_SRAM, 0, 1'b0, "R8");

        // R6: ext_done held high must not shorten non-external accesses
        do_acc(16'h0300, 1'b0, 8'h00, T_SDRAM, WAITS, 1'b1, "R6");
        do_acc(16'h0020, 1'b0, 8'h00, T_SRAM, 0, 1'b1, "R6");

        // R3: reserved code 11 selects the external bus
        do_acc(16'hDF00, 1'b1, 8'hFF, T_REG, 0, 1'b0, "R9");
        do_acc(16'h0000, 1'b0, 8'h00, T_EXT, 2, 1'b0, "R3");
        do_acc(16'hE000, 1'b0, 8'h00, T_EXT, 1, 1'b0, "R3");
        do_acc(16'h5000, 1'b1, 8'h00, T_EXT, 0, 1'b0, "R3");

        // R3: zp=DRAM, stack=SRAM, rom=DRAM, ram=SRAM
        do_acc(16'hDF00, 1'b1, 8'h66, T_REG, 0, 1'b0, "R9");
        do_acc(16'h0000, 1'b0, 8'h00, T_SDRAM, WAITS, 1'b0, "R3");
        do_acc(16'h01AB, 1'b1, 8'h00, T_SRAM, 0, 1'b0, "R3");
        do_acc(16'hF000, 1'b0, 8'h00, T_SDRAM, WAITS, 1'b0, "R3");
        do_acc(16'h5000, 1'b0, 8'h00, T_SRAM, 0, 1'b0, "R3");
        do_acc(16'hD800, 1'b0, 8'h00, T_EXT, 0, 1'b0, "R7");
        do_acc(16'h0500, 1'b1, 8'h00, T_EXT, 2, 1'b0, "R7");

        // R3: writing zero restores the external-bus mapping
        do_acc(16'hDF00, 1'b1, 8'h00, T_REG, 0, 1'b0, "R9");
        do_acc(16'h0000, 1'b0, 8'h00, T_EXT, 1, 1'b0, "R3");

        @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard leftover actual %0d expected 0", exp_q.size());
        end
        checks++;
        if (acc_ready !== 1'b0) begin
            fails++;
            $display("FAIL R10 idle ready actual %0b expected 0", acc_ready);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule